// File: doc/BRIEF.md
# Dual-Port 4-kbit Block RAM with Selectable Clocking

This block is a 4096-bit synchronous memory with two ports, A and B. Each port has its own data input, address, write enable, byte enables, clock enable and read data output. Every port input is captured in an input register before it touches the storage. A write is committed one clock edge after it is captured, as a pulse derived from the registered write enable. Read data can be taken straight from the storage, or through an extra output register chosen per port by a parameter.

The word width can be 16, 8, 4, 2 or 1 bits, and the depth follows so that the total stays at 4096 bits. Two clocks, `clk0` and `clk1`, feed the block. A parameter picks how they are used. In per-port mode, port A runs entirely on `clk0` and port B entirely on `clk1`. In input/output mode, the input registers of both ports run on `clk0` and the output registers of both ports run on `clk1`.

A second parameter turns the block into a simple dual-port memory, where port A only writes and port B only reads. Each port has its own clear for its input side and its own clear for its output side. These clears reset registers only and never touch the stored words. If both ports write the same address in the same cycle, the result is undefined.

Top module: `bram4k_dp`

## Requirements
- R1: `WIDTH` may be 16, 8, 4, 2 or 1. The depth is 4096/`WIDTH` words and the address is log2 of the depth bits wide. Every address from 0 to the last one can be written and read back.
- R2: A write captured at input edge N (`ce`=1, `we`=1) is stored at input edge N+1. A read captured at edge N+1 or later, on either port, returns the new word.
- R3: Without an output register, read data for an address captured at edge N appears after edge N. With an output register, it appears after the next output-clock edge. That is two cycles when both clocks run together.
- R4: A read captured in the same cycle as a write to the same address returns the old word. This holds on the writing port and on the other port.
- R5: With `WIDTH`=16, `be[0]` enables bits [7:0] and `be[1]` enables bits [15:8], and bytes whose enable is 0 keep their old value. With any other width, `be` is ignored and the whole word is written.
- R6: While a port's `ce` is 0, its input and output registers hold and no write is started, so its read data stays unchanged.
- R7: A high `clr_x_out` forces that port's output register to 0. A high `clr_x_in` resets that port's input registers. Neither clear changes the stored words or the other port's output.
- R8: In per-port mode, port A uses only `clk0` and port B uses only `clk1`. With `clk1` stopped, port B neither writes nor changes its output, while port A keeps working.
- R9: In input/output mode, both ports capture inputs on `clk0` and both output registers load on `clk1`. With `clk1` stopped, the registered read data holds until `clk1` runs again.
- R10: With `SIMPLE_DP`=1, port B's `we_b` and `be_b` are ignored and `q_a` stays 0. Port A still writes and port B still reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0 | input | 1 | Port A clock (per-port mode) or input-side clock (input/output mode) |
| clk1 | input | 1 | Port B clock (per-port mode) or output-side clock (input/output mode) |
| clr_a_in | input | 1 | Asynchronous clear, port A input registers, active high |
| clr_a_out | input | 1 | Asynchronous clear, port A output register, active high |
| clr_b_in | input | 1 | Asynchronous clear, port B input registers, active high |
| clr_b_out | input | 1 | Asynchronous clear, port B output register, active high |
| ce_a | input | 1 | Port A clock enable |
| we_a | input | 1 | Port A write enable |
| be_a | input | 2 | Port A byte enables (used only when WIDTH is 16) |
| addr_a | input | AW | Port A address |
| din_a | input | WIDTH | Port A write data |
| q_a | output | WIDTH | Port A read data |
| ce_b | input | 1 | Port B clock enable |
| we_b | input | 1 | Port B write enable |
| be_b | input | 2 | Port B byte enables (used only when WIDTH is 16) |
| addr_b | input | AW | Port B address |
| din_b | input | WIDTH | Port B write data |
| q_b | output | WIDTH | Port B read data |

## Verification
A word is stored as the XOR of two per-port banks. A corrupt bank entry, or a write committed with the wrong byte merge, therefore shows up only when that address is read again. It appears on either port within the read latency, one or two cycles after the address is captured. A pending-write flag that fails to clear shows up as a second, late write. The next read of that address returns data the model does not expect. A clock-selection fault shows up while `clk1` is held. A port that should be frozen moves its output, or a write that should be blocked lands in the array.

// File: rtl/bram4k_pkg.sv
package bram4k_pkg;

    localparam int TOTAL_BITS = 4096;
    localparam int BYTE_BITS  = 8;
    localparam int BE_BITS    = 2;

    typedef enum logic {
        SCHEME_PER_PORT = 1'b0,
        SCHEME_IN_OUT   = 1'b1
    } clk_scheme_e;

endpackage

// File: rtl/bram4k_bank.sv
module bram4k_bank #(
    parameter int W     = 16,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_word,
    input  logic [AW-1:0] rd_addr_0,
    input  logic [AW-1:0] rd_addr_1,
    output logic [W-1:0]  rd_word_0,
    output logic [W-1:0]  rd_word_1
);

    // Two-state storage: banks start at zero so the XOR of two banks is defined.
    bit [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    assign rd_word_0 = mem[rd_addr_0];
    assign rd_word_1 = mem[rd_addr_1];

endmodule

// File: rtl/bram4k_port.sv
module bram4k_port #(
    parameter int W        = 16,
    parameter int AW       = 8,
    parameter bit OUT_REG  = 1'b1,
    parameter bit WRITE_OK = 1'b1,
    parameter bit READ_OK  = 1'b1
) (
    input  logic                        clk_in,
    input  logic                        clk_out,
    input  logic                        clr_in,
    input  logic                        clr_out,
    input  logic                        ce,
    input  logic                        we,
    input  logic [bram4k_pkg::BE_BITS-1:0] be,
    input  logic [AW-1:0]               addr,
    input  logic [W-1:0]                din,
    input  logic [W-1:0]                own_rd,
    input  logic [W-1:0]                other_rd,
    output logic [AW-1:0]               addr_q,
    output logic                        wr_en,
    output logic [W-1:0]                wr_word,
    output logic [W-1:0]                q
);

    localparam bit BYTE_MODE = (W == 2 * bram4k_pkg::BYTE_BITS);

    typedef struct packed {
        logic [AW-1:0]                    addr;
        logic [W-1:0]                     data;
        logic [bram4k_pkg::BE_BITS-1:0]   be;
        logic                             pend;
    } in_regs_t;

    in_regs_t   in_d, in_q;
    logic [W-1:0] cur_word;
    logic [W-1:0] merged;
    logic [W-1:0] raw_rd;

    // Input stage: capture on ce, write pulse is one edge wide.
    always_comb begin
        in_d = in_q;
        if (ce) begin
            in_d.addr = addr;
            in_d.data = din;
            in_d.be   = be;
        end
        in_d.pend = ce && we && WRITE_OK;
    end

    always_ff @(posedge clk_in or posedge clr_in) begin
        if (clr_in) begin
            in_q <= '0;
        end else begin
            in_q <= in_d;
        end
    end

    // Stored word is the XOR of this port's bank and the other bank.
    always_comb begin
        cur_word = own_rd ^ other_rd;
        for (int i = 0; i < W; i++) begin
            if (BYTE_MODE && !in_q.be[i / bram4k_pkg::BYTE_BITS]) begin
                merged[i] = cur_word[i];
            end else begin
                merged[i] = in_q.data[i];
            end
        end
        wr_word = merged ^ other_rd;
        raw_rd  = READ_OK ? cur_word : '0;
    end

    assign addr_q = in_q.addr;
    assign wr_en  = in_q.pend;

    generate
        if (OUT_REG) begin : g_out_reg
            logic [W-1:0] out_d, out_q;

            always_comb begin
                out_d = out_q;
                if (ce) begin
                    out_d = raw_rd;
                end
            end

            always_ff @(posedge clk_out or posedge clr_out) begin
                if (clr_out) begin
                    out_q <= '0;
                end else begin
                    out_q <= out_d;
                end
            end

            assign q = out_q;
        end else begin : g_out_flow
            assign q = raw_rd;
        end
    endgenerate

endmodule

// File: rtl/bram4k_dp.sv
module bram4k_dp #(
    parameter int                      WIDTH     = 16,
    parameter bram4k_pkg::clk_scheme_e SCHEME    = bram4k_pkg::SCHEME_PER_PORT,
    parameter bit                      OUT_REG_A = 1'b1,
    parameter bit                      OUT_REG_B = 1'b1,
    parameter bit                      SIMPLE_DP = 1'b0,
    localparam int                     DEPTH     = bram4k_pkg::TOTAL_BITS / WIDTH,
    localparam int                     AW        = $clog2(DEPTH)
) (
    input  logic             clk0,
    input  logic             clk1,
    input  logic             clr_a_in,
    input  logic             clr_a_out,
    input  logic             clr_b_in,
    input  logic             clr_b_out,
    input  logic             ce_a,
    input  logic             we_a,
    input  logic [1:0]       be_a,
    input  logic [AW-1:0]    addr_a,
    input  logic [WIDTH-1:0] din_a,
    output logic [WIDTH-1:0] q_a,
    input  logic             ce_b,
    input  logic             we_b,
    input  logic [1:0]       be_b,
    input  logic [AW-1:0]    addr_b,
    input  logic [WIDTH-1:0] din_b,
    output logic [WIDTH-1:0] q_b
);

    logic clk_in_a, clk_out_a, clk_in_b, clk_out_b;
    logic [AW-1:0]    addr_q_a, addr_q_b;
    logic             wr_en_a, wr_en_b;
    logic [WIDTH-1:0] wr_word_a, wr_word_b;
    logic [WIDTH-1:0] bank_a_at_a, bank_a_at_b, bank_b_at_a, bank_b_at_b;

    generate
        if (SCHEME == bram4k_pkg::SCHEME_PER_PORT) begin : g_per_port
            assign clk_in_a  = clk0;
            assign clk_out_a = clk0;
            assign clk_in_b  = clk1;
            assign clk_out_b = clk1;
        end else begin : g_in_out
            assign clk_in_a  = clk0;
            assign clk_in_b  = clk0;
            assign clk_out_a = clk1;
            assign clk_out_b = clk1;
        end
    endgenerate

    bram4k_bank #(.W(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_bank_a (
        .clk       (clk_in_a),
        .wr_en     (wr_en_a),
        .wr_addr   (addr_q_a),
        .wr_word   (wr_word_a),
        .rd_addr_0 (addr_q_a),
        .rd_addr_1 (addr_q_b),
        .rd_word_0 (bank_a_at_a),
        .rd_word_1 (bank_a_at_b)
    );

    bram4k_bank #(.W(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_bank_b (
        .clk       (clk_in_b),
        .wr_en     (wr_en_b),
        .wr_addr   (addr_q_b),
        .wr_word   (wr_word_b),
        .rd_addr_0 (addr_q_a),
        .rd_addr_1 (addr_q_b),
        .rd_word_0 (bank_b_at_a),
        .rd_word_1 (bank_b_at_b)
    );

    bram4k_port #(
        .W(WIDTH), .AW(AW), .OUT_REG(OUT_REG_A), .WRITE_OK(1'b1), .READ_OK(!SIMPLE_DP)
    ) u_port_a (
        .clk_in   (clk_in_a),
        .clk_out  (clk_out_a),
        .clr_in   (clr_a_in),
        .clr_out  (clr_a_out),
        .ce       (ce_a),
        .we       (we_a),
        .be       (be_a),
        .addr     (addr_a),
        .din      (din_a),
        .own_rd   (bank_a_at_a),
        .other_rd (bank_b_at_a),
        .addr_q   (addr_q_a),
        .wr_en    (wr_en_a),
        .wr_word  (wr_word_a),
        .q        (q_a)
    );

    bram4k_port #(
        .W(WIDTH), .AW(AW), .OUT_REG(OUT_REG_B), .WRITE_OK(!SIMPLE_DP), .READ_OK(1'b1)
    ) u_port_b (
        .clk_in   (clk_in_b),
        .clk_out  (clk_out_b),
        .clr_in   (clr_b_in),
        .clr_out  (clr_b_out),
        .ce       (ce_b),
        .we       (we_b),
        .be       (be_b),
        .addr     (addr_b),
        .din      (din_b),
        .own_rd   (bank_b_at_b),
        .other_rd (bank_a_at_b),
        .addr_q   (addr_q_b),
        .wr_en    (wr_en_b),
        .wr_word  (wr_word_b),
        .q        (q_b)
    );

endmodule

// File: rtl/bram4k_chk.sv
module bram4k_chk #(
    parameter int W         = 16,
    parameter bit OUT_REG_A = 1'b1,
    parameter bit OUT_REG_B = 1'b1,
    parameter bit SIMPLE_DP = 1'b0
) (
    input logic         clk_in_a,
    input logic         clk_out_a,
    input logic         clk_in_b,
    input logic         clk_out_b,
    input logic         clr_a_in,
    input logic         clr_a_out,
    input logic         clr_b_in,
    input logic         clr_b_out,
    input logic         ce_a,
    input logic         ce_b,
    input logic         we_a,
    input logic         we_b,
    input logic         wr_en_a,
    input logic         wr_en_b,
    input logic [W-1:0] q_a,
    input logic [W-1:0] q_b
);

    // R2: a commit pulse only follows a captured write
    a_r2_commit_follows_write_a: assert property (@(posedge clk_in_a) disable iff (clr_a_in)
        wr_en_a |-> $past(ce_a && we_a));

    a_r2_commit_follows_write_b: assert property (@(posedge clk_in_b) disable iff (clr_b_in)
        wr_en_b |-> $past(ce_b && we_b));

    // R6: output register holds while ce is low
    a_r6_hold_a: assert property (@(posedge clk_out_a) disable iff (clr_a_out || !OUT_REG_A)
        !ce_a |=> $stable(q_a));

    a_r6_hold_b: assert property (@(posedge clk_out_b) disable iff (clr_b_out || !OUT_REG_B)
        !ce_b |=> $stable(q_b));

    // R7: a held output clear keeps the registered data at zero
    a_r7_out_clear_a: assert property (@(posedge clk_out_a)
        (clr_a_out && OUT_REG_A) |-> (q_a == '0));

    a_r7_out_clear_b: assert property (@(posedge clk_out_b)
        (clr_b_out && OUT_REG_B) |-> (q_b == '0));

    // R10: simple dual-port keeps port B from writing and port A from reading
    a_r10_b_no_write: assert property (@(posedge clk_in_b) disable iff (clr_b_in)
        SIMPLE_DP |-> !wr_en_b);

    a_r10_a_reads_zero: assert property (@(posedge clk_in_a) disable iff (clr_a_in || clr_a_out)
        SIMPLE_DP |-> (q_a == '0));

endmodule

bind bram4k_dp bram4k_chk #(
    .W(WIDTH), .OUT_REG_A(OUT_REG_A), .OUT_REG_B(OUT_REG_B), .SIMPLE_DP(SIMPLE_DP)
) u_chk (.*);

// File: tb/bram4k_dp_tb.sv
module bram4k_dp_tb;

    logic clk0 = 1'b0;
    logic clk1_en = 1'b1;
    logic clk1;
    always #5 clk0 = ~clk0;
    assign clk1 = clk0 & clk1_en;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk0) cyc <= cyc + 1;

    // ---------------- DUT 1: per-port clocks, output registers, x16 ----------------
    logic clr_a_in = 1, clr_a_out = 1, clr_b_in = 1, clr_b_out = 1;
    logic ce_a = 0, we_a = 0, ce_b = 0, we_b = 0;
    logic [1:0]  be_a = 0, be_b = 0;
    logic [7:0]  addr_a = 0, addr_b = 0;
    logic [15:0] din_a = 0, din_b = 0;
    logic [15:0] q_a, q_b;

    bram4k_dp u_dut (
        .clk0(clk0), .clk1(clk1),
        .clr_a_in(clr_a_in), .clr_a_out(clr_a_out), .clr_b_in(clr_b_in), .clr_b_out(clr_b_out),
        .ce_a(ce_a), .we_a(we_a), .be_a(be_a), .addr_a(addr_a), .din_a(din_a), .q_a(q_a),
        .ce_b(ce_b), .we_b(we_b), .be_b(be_b), .addr_b(addr_b), .din_b(din_b), .q_b(q_b)
    );

    // ---------------- DUT 2: input/output clocks, simple dual-port, x4 ----------------
    logic t_clr = 1;
    logic t_ce_a = 0, t_we_a = 0, t_ce_b = 0, t_we_b = 0;
    logic [1:0] t_be_a = 0, t_be_b = 0;
    logic [9:0] t_addr_a = 0, t_addr_b = 0;
    logic [3:0] t_din_a = 0, t_din_b = 0;
    logic [3:0] t_q_a, t_q_b;

    bram4k_dp #(
        .WIDTH(4), .SCHEME(bram4k_pkg::SCHEME_IN_OUT),
        .OUT_REG_A(1'b0), .OUT_REG_B(1'b1), .SIMPLE_DP(1'b1)
    ) u_dut_io (
        .clk0(clk0), .clk1(clk1),
        .clr_a_in(t_clr), .clr_a_out(t_clr), .clr_b_in(t_clr), .clr_b_out(t_clr),
        .ce_a(t_ce_a), .we_a(t_we_a), .be_a(t_be_a), .addr_a(t_addr_a), .din_a(t_din_a), .q_a(t_q_a),
        .ce_b(t_ce_b), .we_b(t_we_b), .be_b(t_be_b), .addr_b(t_addr_b), .din_b(t_din_b), .q_b(t_q_b)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------------- scoreboard for DUT 1 ----------------
    typedef struct {
        int          due;
        logic [15:0] exp;
        string       tag;
    } item_t;

    typedef struct {
        bit          ce;
        bit          wr;
        bit          rd;
        logic [1:0]  be;
        logic [7:0]  addr;
        logic [15:0] data;
    } op_t;

    item_t qa[$];
    item_t qb[$];
    logic [15:0] model [256];

    function automatic op_t op_wr(logic [7:0] a, logic [15:0] d, logic [1:0] be);
        op_t o; o.ce = 1; o.wr = 1; o.rd = 0; o.be = be; o.addr = a; o.data = d; return o;
    endfunction
    function automatic op_t op_rw(logic [7:0] a, logic [15:0] d);
        op_t o; o.ce = 1; o.wr = 1; o.rd = 1; o.be = 2'b11; o.addr = a; o.data = d; return o;
    endfunction
    function automatic op_t op_rd(logic [7:0] a);
        op_t o; o.ce = 1; o.wr = 0; o.rd = 1; o.be = 2'b11; o.addr = a; o.data = 16'h0; return o;
    endfunction
    function automatic op_t op_nop();
        op_t o; o.ce = 1; o.wr = 0; o.rd = 0; o.be = 2'b00; o.addr = 8'h0; o.data = 16'h0; return o;
    endfunction

    function automatic logic [15:0] bmerge(logic [15:0] old, logic [15:0] nw, logic [1:0] be);
        return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
    endfunction

    // Driver: one cycle on both ports; expectations use the model before this cycle's writes.
    task automatic step(op_t a, op_t b, string tag);
        int n;
        @(negedge clk0);
        n = cyc + 1;
        ce_a = a.ce; we_a = a.wr; be_a = a.be; addr_a = a.addr; din_a = a.data;
        ce_b = b.ce; we_b = b.wr; be_b = b.be; addr_b = b.addr; din_b = b.data;
        if (a.ce && a.rd) qa.push_back('{due: n + 1, exp: model[a.addr], tag: {tag, " port A"}});
        if (b.ce && b.rd) qb.push_back('{due: n + 1, exp: model[b.addr], tag: {tag, " port B"}});
        if (a.ce && a.wr) model[a.addr] = bmerge(model[a.addr], a.data, a.be);
        if (b.ce && b.wr) model[b.addr] = bmerge(model[b.addr], b.data, b.be);
    endtask

    task automatic drain();
        repeat (3) step(op_nop(), op_nop(), "drain");
    endtask

    // Monitor: compares results when their cycle comes up.
    item_t it_a, it_b;
    always @(negedge clk0) begin
        while (qa.size() > 0 && qa[0].due <= cyc) begin
            it_a = qa.pop_front();
            check(it_a.tag, q_a, it_a.exp);
        end
        while (qb.size() > 0 && qb[0].due <= cyc) begin
            it_b = qb.pop_front();
            check(it_b.tag, q_b, it_b.exp);
        end
    end

    // ---------------- DUT 2 helpers ----------------
    task automatic t2_write(logic [9:0] a, logic [3:0] d, logic [1:0] be);
        @(negedge clk0);
        t_ce_a = 1; t_we_a = 1; t_addr_a = a; t_din_a = d; t_be_a = be;
        @(negedge clk0);
        t_we_a = 0;
    endtask

    task automatic t2_read(logic [9:0] a, output logic [3:0] v);
        @(negedge clk0);
        t_ce_b = 1; t_we_b = 0; t_addr_b = a;
        @(negedge clk0);
        @(negedge clk0);
        v = t_q_b;
    endtask

    logic [15:0] hold_a, hold_b;
    logic [3:0]  rv;

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 16'h0;

        // Reset state (R7)
        repeat (3) @(negedge clk0);
        check("R7 reset q_a", q_a, 16'h0);
        check("R7 reset q_b", q_b, 16'h0);
        check("R10 reset t_q_a", {12'h0, t_q_a}, 16'h0);
        check("R7 reset t_q_b", {12'h0, t_q_b}, 16'h0);
        clr_a_in = 0; clr_a_out = 0; clr_b_in = 0; clr_b_out = 0; t_clr = 0;

        // R2: writes on both ports, then cross-port reads
        step(op_wr(8'd10, 16'h1111, 2'b11), op_wr(8'd20, 16'h3333, 2'b11), "R2 write");
        step(op_wr(8'd11, 16'h2222, 2'b11), op_nop(), "R2 write");
        step(op_rd(8'd20), op_rd(8'd10), "R2 cross read");
        step(op_rd(8'd11), op_rd(8'd11), "R3 latency read");
        step(op_rd(8'd10), op_rd(8'd20), "R2 own read");

        // R1: last address of the x16 array
        step(op_wr(8'd255, 16'hCAFE, 2'b11), op_nop(), "R1 top write");
        step(op_nop(), op_rd(8'd255), "R1 top address");

        // R5: byte enables in x16 mode
        step(op_wr(8'd30, 16'hAAAA, 2'b11), op_nop(), "R5 full");
        step(op_wr(8'd30, 16'h1234, 2'b01), op_nop(), "R5 low byte");
        step(op_nop(), op_rd(8'd30), "R5 low byte merge");
        step(op_wr(8'd30, 16'h5678, 2'b10), op_nop(), "R5 high byte");
        step(op_nop(), op_rd(8'd30), "R5 high byte merge");
        step(op_nop(), op_wr(8'd30, 16'hFFFF, 2'b00), "R5 no byte");
        step(op_rd(8'd30), op_nop(), "R5 no byte enabled");

        // R4: read during write returns old word on both ports
        step(op_wr(8'd40, 16'h1000, 2'b11), op_nop(), "R4 seed");
        step(op_rw(8'd40, 16'h4444), op_rd(8'd40), "R4 read during write");
        step(op_nop(), op_rd(8'd40), "R4 after write");
        drain();

        // R6: clock enable low blocks capture and holds output
        @(negedge clk0);
        hold_a = q_a;
        ce_a = 0; we_a = 1; addr_a = 8'd10; din_a = 16'hBEEF; be_a = 2'b11;
        repeat (3) @(negedge clk0);
        check("R6 q_a holds with ce low", q_a, hold_a);
        step(op_rd(8'd10), op_nop(), "R6 write ignored");
        drain();

        // R7: output clear on port A only, stored words kept
        @(negedge clk0);
        hold_b = q_b;
        clr_a_out = 1;
        @(negedge clk0);
        check("R7 q_a cleared", q_a, 16'h0);
        check("R7 q_b untouched", q_b, hold_b);
        clr_a_out = 0;
        step(op_rd(8'd10), op_nop(), "R7 array kept after out clear");
        drain();
        @(negedge clk0);
        clr_a_in = 1;
        @(negedge clk0);
        clr_a_in = 0;
        step(op_rd(8'd11), op_nop(), "R7 array kept after in clear");
        drain();

        // R8: clk1 stopped freezes port B only
        @(negedge clk0);
        clk1_en = 0;
        hold_b = q_b;
        ce_b = 1; we_b = 1; addr_b = 8'd10; din_b = 16'h9999; be_b = 2'b11;
        ce_a = 1; we_a = 1; addr_a = 8'd60; din_a = 16'h6060; be_a = 2'b11;
        model[60] = 16'h6060;
        @(negedge clk0);
        we_a = 0; addr_a = 8'd0;
        @(negedge clk0);
        check("R8 q_b frozen", q_b, hold_b);
        we_b = 0; ce_b = 0;
        clk1_en = 1;
        step(op_rd(8'd10), op_nop(), "R8 port B write blocked");
        step(op_rd(8'd60), op_nop(), "R8 port A ran alone");
        drain();

        // ---------------- DUT 2 ----------------
        t2_write(10'd5, 4'hA, 2'b00);
        t2_write(10'd6, 4'h3, 2'b00);
        t2_write(10'd1023, 4'h7, 2'b00);
        t2_read(10'd5, rv);
        check("R5 narrow word ignores be", {12'h0, rv}, 16'h000A);
        t2_read(10'd1023, rv);
        check("R1 x4 top address", {12'h0, rv}, 16'h0007);
        @(negedge clk0);
        t_ce_b = 1; t_we_b = 1; t_addr_b = 10'd6; t_din_b = 4'hF; t_be_b = 2'b11;
        @(negedge clk0);
        t_we_b = 0;
        t2_read(10'd6, rv);
        check("R10 port B write ignored", {12'h0, rv}, 16'h0003);
        check("R10 q_a stays zero", {12'h0, t_q_a}, 16'h0);

        // R9: output side frozen while clk1 stopped
        @(negedge clk0);
        clk1_en = 0;
        t_addr_b = 10'd5;
        repeat (2) @(negedge clk0);
        check("R9 output reg holds without clk1", {12'h0, t_q_b}, 16'h0003);
        clk1_en = 1;
        @(negedge clk0);
        check("R9 output reg loads on clk1", {12'h0, t_q_b}, 16'h000A);

        repeat (2) @(negedge clk0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk0);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule